// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from a chip and presents them to a processor as one interrupt line. It has two banks. The main bank has 40 sources. The auxiliary bank has 32 sources, and it feeds main source 0: whenever an auxiliary source is both pending and enabled, main source 0 sees a request. Each bank latches requests into a pending vector. Software enables sources by writing ones to a set register and disables them by writing ones to a clear register. It acknowledges pending bits by writing ones to an acknowledge register.

A read-only index register returns the lowest-numbered main source that is both enabled and pending. When that value is 0, the handler goes on to the auxiliary status word. A table of 40 channel-map registers is reset so that each entry holds its own index. Software can rewrite any entry. The table does not change how requests are handled.

Software reaches everything over a simple 32-bit register bus. Writes take effect at the clock edge on which the write strobe is high. Read data follows the address combinationally. Accesses are word aligned, and an address with bits [1:0] not zero matches no register.

Top module: `irqc_top`

## Requirements
- R1: After reset the following hold. All enables are 0, all pending bits are 0 and `irq_o` is low. The index register reads 0. Channel-map entry n reads back n.
- R2: A high main request sets its pending bit on the next clock edge. The bit stays set after the request drops. Main pending bits 0..31 read at 0x00, and bits 32..39 read in bits [7:0] of 0x04.
- R3: Writing ones to 0x20 (sources 0..31) or 0x24 (sources 32..39, bits [7:0]) enables those sources. Zero bits leave the enables unchanged. The current enables read back at the same two addresses.
- R4: Writing ones to 0x30 or 0x34 disables the matching main sources. Zero bits have no effect.
- R5: Writing ones to 0x10 or 0x14 acknowledges the matching main pending bits. A bit whose request has dropped reads 0 afterwards. A bit whose request is still high stays set.
- R6: `irq_o` is high exactly when some main source is both enabled and pending. It rises one cycle after the request. Pending sources that are not enabled do not raise it.
- R7: Register 0x40 returns, in bits [5:0], the lowest-numbered main source that is enabled and pending. It returns 0 when there is none. All other bits read 0.
- R8: The auxiliary bank uses the same write-one rules. Status reads at 0x80, acknowledge is at 0x88, enable-set is at 0x90 (which also reads back the enables) and enable-clear is at 0x98.
- R9: Any auxiliary source that is enabled and pending sets main pending bit 0 on the following edge. This is two cycles after the auxiliary request.
- R10: Channel-map entry n is at 0x200 + 4·n for n = 0..39. Each entry is 6 bits wide and can be read and written. Addresses from 0x2A0 upward read 0 and ignore writes.
- R11: Bits [31:8] of 0x04 and 0x24 read 0. Writes to those bit positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pri_req_i | input | 40 | Main bank level requests |
| sec_req_i | input | 32 | Auxiliary bank level requests |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
A register write lands on the edge on which the strobe is high. Its effect therefore shows at the next falling edge, and reads, being combinational, can be sampled at any point in the low phase. A main request reaches pending and `irq_o` one edge after it is driven. An auxiliary request needs two edges: one to reach auxiliary pending, and one more through the merge into main source 0. The bench drives all inputs on falling edges. For every expectation it pushes an item that a monitor compares 2 ns after that same falling edge. Where the timing matters, the driver leaves exactly the required number of edges between stimulus and check: for example, `irq_o` is checked low in the cycle the request is driven and high one cycle later.

// File: rtl/irqc_pkg.sv
// Package: bus width and the register offsets that software relies on.
// Assumes byte addressing with 32-bit word-aligned registers.
package irqc_pkg;
    localparam int BUS_W        = 32;
    localparam int OFF_PRI_STAT = 'h000;
    localparam int OFF_PRI_ACK  = 'h010;
    localparam int OFF_PRI_ENS  = 'h020;
    localparam int OFF_PRI_ENC  = 'h030;
    localparam int OFF_PRIO     = 'h040;
    localparam int OFF_SEC_STAT = 'h080;
    localparam int OFF_SEC_ACK  = 'h088;
    localparam int OFF_SEC_ENS  = 'h090;
    localparam int OFF_SEC_ENC  = 'h098;
    localparam int OFF_CHMAP    = 'h200;

    // Number of bus words needed to hold n source bits.
    function automatic int words_for(input int n);
        return (n + BUS_W - 1) / BUS_W;
    endfunction
endpackage

// File: rtl/irqc_src_bank.sv
// Source bank: latches level requests into pending bits and holds the
// per-source enables. All control inputs are one-hot-per-bit masks that
// come from decoded write-one register writes.
// Assumes that set and clear of the same enable never arrive together
// (they live at separate addresses); if they do, clear wins.
module irqc_src_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] ack_i,
    input  logic [WIDTH-1:0] en_set_i,
    input  logic [WIDTH-1:0] en_clr_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] en_o,
    output logic [WIDTH-1:0] active_o
);
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] en_q;

    // Pending: acknowledge drops a bit, a live request sets it again.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_i) | req_i;
    end

    // Enables: write-one set, write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | en_set_i) & ~en_clr_i;
    end

    assign pend_o   = pend_q;
    assign en_o     = en_q;
    assign active_o = pend_q & en_q;

    a_r2_req_latched: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(req_i)) == $past(req_i)));
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(ack_i & ~req_i)) == '0));
    a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_set_i & ~en_clr_i)) == $past(en_set_i & ~en_clr_i)));
    a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_clr_i)) == '0));
endmodule

// File: rtl/irqc_prio_enc.sv
// Priority encoder: returns the index of the lowest set bit of vec_i.
// Purely combinational; clk and rst_n serve only the checks.
module irqc_prio_enc #(
    parameter int WIDTH = 40,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);
    // Scan from the top so the lowest set bit is the last to overwrite.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end

    a_r7_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> vec_i[idx_o]);
    a_r7_no_lower_active: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> ((vec_i & ((WIDTH'(1) << idx_o) - WIDTH'(1))) == '0));
endmodule

// File: rtl/irqc_chan_map.sv
// Channel map table: NUM_CH small registers, each reset to its own index.
// Stores only; the values do not steer any request.
module irqc_chan_map #(
    parameter int NUM_CH = 40,
    parameter int CH_W   = 6,
    parameter int SEL_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEL_W-1:0] idx_i,
    input  logic [CH_W-1:0]  wdata_i,
    output logic [CH_W-1:0]  rdata_o
);
    logic [CH_W-1:0] map_q [NUM_CH];
    logic            in_range;

    assign in_range = (int'(idx_i) < NUM_CH);

    // Table update: reset to identity, otherwise a write into range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) map_q[i] <= CH_W'(i);
        end else if (we_i && in_range) begin
            map_q[idx_i] <= wdata_i;
        end
    end

    // Read port: out-of-range entries read as zero.
    always_comb begin
        rdata_o = '0;
        if (in_range) rdata_o = map_q[idx_i];
    end

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && in_range) |=> (map_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/irqc_top.sv
// Cascaded interrupt controller top: decodes the register bus, builds the
// write-one masks for both banks, merges the auxiliary bank into main
// source 0 and drives the read mux and the processor interrupt line.
// Assumes word-aligned accesses; the read data is combinational.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_PRI = 40,
    parameter int NUM_SEC = 32,
    parameter int CH_W    = 6,
    parameter int ADDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_PRI-1:0] pri_req_i,
    input  logic [NUM_SEC-1:0] sec_req_i,
    output logic              irq_o
);
    localparam int PRI_WORDS = words_for(NUM_PRI);
    localparam int PIDX_W    = (NUM_PRI > 1) ? $clog2(NUM_PRI) : 1;
    localparam int SEL_W     = ADDR_W - 2;
    localparam int MAP_END   = OFF_CHMAP + 4 * NUM_PRI;

    logic [NUM_PRI-1:0] pri_ack, pri_ens, pri_enc, pri_req;
    logic [NUM_PRI-1:0] pri_pend, pri_en, pri_active;
    logic [NUM_SEC-1:0] sec_ack, sec_ens, sec_enc;
    logic [NUM_SEC-1:0] sec_pend, sec_en, sec_active;
    logic [PRI_WORDS-1:0] hit_ack, hit_ens, hit_enc, hit_stat;
    logic [PIDX_W-1:0]  prio_idx;
    logic               prio_found;
    logic               cascade;
    logic               map_hit;
    logic [SEL_W-1:0]   map_idx;
    logic [CH_W-1:0]    map_rd;

    // Per-word address hits for the main bank register groups.
    for (genvar k = 0; k < PRI_WORDS; k++) begin : g_word_hit
        assign hit_stat[k] = (bus_addr == ADDR_W'(OFF_PRI_STAT + 4 * k));
        assign hit_ack[k]  = bus_wr && (bus_addr == ADDR_W'(OFF_PRI_ACK + 4 * k));
        assign hit_ens[k]  = bus_wr && (bus_addr == ADDR_W'(OFF_PRI_ENS + 4 * k));
        assign hit_enc[k]  = bus_wr && (bus_addr == ADDR_W'(OFF_PRI_ENC + 4 * k));
    end

    // Per-bit write-one masks for the main bank.
    for (genvar i = 0; i < NUM_PRI; i++) begin : g_pri_mask
        assign pri_ack[i] = hit_ack[i / BUS_W] & bus_wdata[i % BUS_W];
        assign pri_ens[i] = hit_ens[i / BUS_W] & bus_wdata[i % BUS_W];
        assign pri_enc[i] = hit_enc[i / BUS_W] & bus_wdata[i % BUS_W];
    end

    // Write-one masks for the auxiliary bank.
    assign sec_ack = (bus_wr && bus_addr == ADDR_W'(OFF_SEC_ACK)) ? bus_wdata[NUM_SEC-1:0] : '0;
    assign sec_ens = (bus_wr && bus_addr == ADDR_W'(OFF_SEC_ENS)) ? bus_wdata[NUM_SEC-1:0] : '0;
    assign sec_enc = (bus_wr && bus_addr == ADDR_W'(OFF_SEC_ENC)) ? bus_wdata[NUM_SEC-1:0] : '0;

    irqc_src_bank #(.WIDTH(NUM_SEC)) u_sec_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (sec_req_i),
        .ack_i    (sec_ack),
        .en_set_i (sec_ens),
        .en_clr_i (sec_enc),
        .pend_o   (sec_pend),
        .en_o     (sec_en),
        .active_o (sec_active)
    );

    // Merge: any live auxiliary source requests main source 0.
    assign cascade = |sec_active;
    assign pri_req = {pri_req_i[NUM_PRI-1:1], pri_req_i[0] | cascade};

    irqc_src_bank #(.WIDTH(NUM_PRI)) u_pri_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (pri_req),
        .ack_i    (pri_ack),
        .en_set_i (pri_ens),
        .en_clr_i (pri_enc),
        .pend_o   (pri_pend),
        .en_o     (pri_en),
        .active_o (pri_active)
    );

    irqc_prio_enc #(.WIDTH(NUM_PRI)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec_i   (pri_active),
        .idx_o   (prio_idx),
        .found_o (prio_found)
    );

    // Channel map window decode.
    assign map_hit = (int'(bus_addr) >= OFF_CHMAP) && (int'(bus_addr) < MAP_END)
                     && (bus_addr[1:0] == 2'b00);
    assign map_idx = bus_addr[ADDR_W-1:2] - SEL_W'(OFF_CHMAP / 4);

    irqc_chan_map #(.NUM_CH(NUM_PRI), .CH_W(CH_W), .SEL_W(SEL_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_wr && map_hit),
        .idx_i   (map_idx),
        .wdata_i (bus_wdata[CH_W-1:0]),
        .rdata_o (map_rd)
    );

    // Extract bus word k of a main-bank vector, zero past the last source.
    function automatic logic [BUS_W-1:0] pri_word(input logic [NUM_PRI-1:0] v, input int k);
        logic [BUS_W-1:0] w;
        w = '0;
        for (int j = 0; j < BUS_W; j++) begin
            if (k * BUS_W + j < NUM_PRI) w[j] = v[k * BUS_W + j];
        end
        return w;
    endfunction

    // Read mux over all readable registers.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < PRI_WORDS; k++) begin
            if (hit_stat[k]) bus_rdata = pri_word(pri_pend, k);
            if (bus_addr == ADDR_W'(OFF_PRI_ENS + 4 * k)) bus_rdata = pri_word(pri_en, k);
        end
        if (bus_addr == ADDR_W'(OFF_PRIO))     bus_rdata = BUS_W'(prio_idx);
        if (bus_addr == ADDR_W'(OFF_SEC_STAT)) bus_rdata = BUS_W'(sec_pend);
        if (bus_addr == ADDR_W'(OFF_SEC_ENS))  bus_rdata = BUS_W'(sec_en);
        if (map_hit)                           bus_rdata = BUS_W'(map_rd);
    end

    assign irq_o = |pri_active;

    a_r9_cascade_into_src0: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |=> pri_pend[0]);
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((|pri_en) && prio_found));
    a_r7_index_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_found |-> (prio_idx == '0));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [39:0] pri_req_i = '0;
    logic [31:0] sec_req_i = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [9:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pri_req_i(pri_req_i),
        .sec_req_i(sec_req_i), .irq_o(irq_o)
    );

    // Monitor: pops expected items 2 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = it.is_irq ? {31'b0, irq_o} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    // Drive a main request and check irq_o in that same cycle.
    task automatic pri_req_now(input logic [39:0] r, input logic e, input string tag);
        item_t it;
        @(negedge clk);
        pri_req_i = r;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(10'h000, 32'h0, "R1");
        chk_rd(10'h004, 32'h0, "R1");
        chk_rd(10'h020, 32'h0, "R1");
        chk_rd(10'h024, 32'h0, "R1");
        chk_rd(10'h080, 32'h0, "R1");
        chk_rd(10'h090, 32'h0, "R1");
        chk_rd(10'h040, 32'h0, "R1");
        chk_irq(1'b0, "R1");
        chk_rd(10'h200, 32'd0, "R1");
        chk_rd(10'h204, 32'd1, "R1");
        chk_rd(10'h29C, 32'd39, "R1");
        // R2 latching; R6 not enabled so no irq
        pri_req_now((40'd1 << 5) | (40'd1 << 35), 1'b0, "R6");
        chk_rd(10'h000, 32'h20, "R2");
        chk_rd(10'h004, 32'h8, "R2");
        chk_irq(1'b0, "R6");
        chk_rd(10'h040, 32'h0, "R7");
        // R3 enable set
        wr(10'h024, 32'h8);
        chk_rd(10'h024, 32'h8, "R3");
        chk_irq(1'b1, "R6");
        chk_rd(10'h040, 32'd35, "R7");
        wr(10'h020, 32'h120);
        chk_rd(10'h020, 32'h120, "R3");
        chk_rd(10'h040, 32'd5, "R7");
        wr(10'h020, 32'h0);
        chk_rd(10'h020, 32'h120, "R3");
        // R11 unused upper bits
        wr(10'h024, 32'hFFFF_FF00);
        chk_rd(10'h024, 32'h8, "R11");
        // R4 enable clear
        wr(10'h030, 32'h20);
        chk_rd(10'h020, 32'h100, "R4");
        chk_rd(10'h040, 32'd35, "R7");
        wr(10'h034, 32'h8);
        chk_rd(10'h024, 32'h0, "R4");
        chk_irq(1'b0, "R6");
        chk_rd(10'h040, 32'h0, "R7");
        // R5 acknowledge
        @(negedge clk); pri_req_i = '0;
        chk_rd(10'h000, 32'h20, "R2");
        wr(10'h010, 32'h20);
        chk_rd(10'h000, 32'h0, "R5");
        @(negedge clk); pri_req_i = 40'd1 << 35;
        wr(10'h014, 32'h8);
        chk_rd(10'h004, 32'h8, "R5");
        @(negedge clk); pri_req_i = '0;
        wr(10'h014, 32'h8);
        chk_rd(10'h004, 32'h0, "R5");
        // R6 one-cycle timing
        wr(10'h020, 32'h200);
        pri_req_now(40'd1 << 9, 1'b0, "R6");
        chk_irq(1'b1, "R6");
        chk_rd(10'h040, 32'd9, "R7");
        @(negedge clk); pri_req_i = '0;
        wr(10'h010, 32'h200);
        wr(10'h030, 32'h200);
        chk_irq(1'b0, "R6");
        // R8 / R9 auxiliary bank and merge
        @(negedge clk); sec_req_i = 32'h80;
        chk_rd(10'h080, 32'h80, "R8");
        chk_rd(10'h000, 32'h0, "R9");
        wr(10'h090, 32'h80);
        chk_rd(10'h090, 32'h80, "R8");
        chk_rd(10'h000, 32'h1, "R9");
        wr(10'h020, 32'h1);
        chk_irq(1'b1, "R9");
        chk_rd(10'h040, 32'h0, "R7");
        wr(10'h098, 32'h80);
        chk_rd(10'h090, 32'h0, "R8");
        @(negedge clk); sec_req_i = '0;
        wr(10'h088, 32'h80);
        chk_rd(10'h080, 32'h0, "R8");
        wr(10'h010, 32'h1);
        chk_rd(10'h000, 32'h0, "R9");
        chk_irq(1'b0, "R6");
        // R10 channel map
        wr(10'h208, 32'h2A);
        chk_rd(10'h208, 32'h2A, "R10");
        chk_rd(10'h20C, 32'd3, "R10");
        chk_rd(10'h2A0, 32'h0, "R10");
        wr(10'h2A0, 32'h15);
        chk_rd(10'h2A0, 32'h0, "R10");
        chk_rd(10'h29C, 32'd39, "R10");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule